// File: doc/BRIEF.md
# ARINC 429 FIFO Transmitter

This block queues 31-bit data words and sends each one as a 32-bit ARINC 429 serial word. It adds a generated parity bit as the final bit. A host writes every word over a 16-bit bus in two steps: a low-half strobe captures the first 16 bits, and a high-half strobe commits the complete word into an eight-entry queue. When the start enable is high and the queue holds a word, the head entry moves into a shift register. It is then sent least significant bit first, in return-to-zero form, on a pair of digital line outputs.

All timing comes from the master clock. Each bit is one half-bit of data level followed by one half-bit of null. A half-bit is 5 clocks at the fast rate and 40 clocks at the slow rate. After the data half of the last bit, the lines stay null for eight half-bits before the next word can begin. A ready flag shows when nothing remains to be sent. A test input forces the line outputs to null. A loopback enable copies the encoded stream onto two receiver-side pairs: the first pair gets it as sent, and the second gets it with ones and zeros swapped.

Top module: `a429_tx`

## Requirements
- R1: While reset is asserted and just after it is released, txReady is 1 and lineA and lineB are both 0.
- R2: A word is committed only by loadHi after a loadLo. The word is {busData[14:0] at loadHi, busData[15:0] at loadLo}, and busData[15] at loadHi is ignored. A loadHi without a preceding loadLo commits nothing, and a second loadLo replaces the first.
- R3: The queue holds 8 words. A commit attempted while 8 words are queued is dropped, and only the 8 queued words are ever sent.
- R4: txReady is 0 whenever a word is queued or bits of a word are still being sent. It returns to 1 once the queue is empty and the data half of the last bit has ended.
- R5: Each bit is a data half followed by a null half, each half being 5 clocks when slowRate is 0 and 40 clocks when slowRate is 1. The first data half starts on the clock edge that samples startEn high with a non-empty queue.
- R6: Word bit 0 is sent first and word bit 30 is sent 31st. The 32nd bit is the parity bit.
- R7: The parity bit makes the number of ones in all 32 bits odd when evenParity is 0, and even when evenParity is 1.
- R8: After the data half of bit 32, the lines are null for 8 half-bits (40 or 320 clocks). A following word then starts at once if startEn is high and a word is queued.
- R9: With startEn low, no new word starts. A word already started is always sent to its end.
- R10: The line encoding is: a one drives lineA=1 and lineB=0, a zero drives lineA=0 and lineB=1, and null drives both to 0.
- R11: lineTest=1 forces lineA and lineB to 0 but does not alter the loopback outputs.
- R12: With loopEn=1, loopRx1A/loopRx1B carry the encoded level as on the lines, and loopRx2A/loopRx2B carry it with A and B swapped. With loopEn=0 all four are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rstN | input | 1 | Asynchronous reset, active low |
| busData | input | 16 | Host data bus |
| loadLo | input | 1 | Captures the low half of a word |
| loadHi | input | 1 | Supplies the high half and commits the word |
| startEn | input | 1 | Allows words to start |
| slowRate | input | 1 | 0: 10-clock bit, 1: 80-clock bit |
| evenParity | input | 1 | 0: odd parity, 1: even parity |
| lineTest | input | 1 | Forces the line outputs to null |
| loopEn | input | 1 | Enables the loopback outputs |
| txReady | output | 1 | Queue empty and nothing left to send |
| lineA | output | 1 | Line output A |
| lineB | output | 1 | Line output B |
| loopRx1A | output | 1 | Loopback to receiver 1, A side |
| loopRx1B | output | 1 | Loopback to receiver 1, B side |
| loopRx2A | output | 1 | Loopback to receiver 2 (swapped), A side |
| loopRx2B | output | 1 | Loopback to receiver 2 (swapped), B side |

## Verification
Two situations are hard to reach from the ports. One is a commit arriving when all eight entries are already waiting. The other is the start enable falling between words while a word is still queued. The stimulus keeps startEn low while it writes nine words, so the ninth meets a full queue. It then counts the data pulses on the lines to confirm that exactly eight words come out. For the second case, it drops startEn part way through the first of two queued words. It then holds it low long enough to see that the first word finishes, the second never starts, and the ready flag stays low until startEn returns.

// File: rtl/a429_tx_pkg.sv
package a429_tx_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_MARK,   // data half of a bit
    ST_SPACE,  // null half of a bit
    ST_GAP     // inter-word null
  } txState_e;

  typedef struct packed {
    logic loadWord;  // pop queue head into shifter
    logic nextBit;   // advance shifter by one bit
    logic drive;     // present data level on the line
  } txStrobe_t;

endpackage

// File: rtl/a429_tx_path.sv
module a429_tx_path
  import a429_tx_pkg::*;
#(
  parameter int DEPTH     = 8,
  parameter int WORD_BITS = 32,
  parameter int BUS_W     = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [BUS_W-1:0] busData,
  input  logic             loadLo,
  input  logic             loadHi,
  input  logic             evenParity,
  input  txStrobe_t        strb,
  output logic             fifoEmpty,
  output logic             levelA,
  output logic             levelB
);

  localparam int DATA_W = WORD_BITS - 1;
  localparam int HI_W   = DATA_W - BUS_W;
  localparam int PTR_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W  = $clog2(DEPTH + 1);

  logic [DATA_W-1:0]    mem [DEPTH];
  logic [PTR_W-1:0]     rdPtr, wrPtr;
  logic [CNT_W-1:0]     count;
  logic [BUS_W-1:0]     loHold;
  logic                 loValid;
  logic [WORD_BITS-1:0] shiftReg;
  logic [DATA_W-1:0]    headWord;
  logic                 parityBit;
  logic                 commit;
  logic                 pop;
  logic                 spareUnused;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  assign spareUnused = busData[BUS_W-1];
  assign commit      = loadHi && loValid && (count != CNT_W'(DEPTH));
  assign pop         = strb.loadWord;
  assign fifoEmpty   = (count == '0);
  assign headWord    = mem[rdPtr];
  assign parityBit   = ~(^headWord) ^ evenParity;

  always_ff @(posedge clk) begin
    if (commit) mem[wrPtr] <= {busData[HI_W-1:0], loHold};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      loHold  <= '0;
      loValid <= 1'b0;
    end else if (loadHi) begin
      loValid <= 1'b0;
    end else if (loadLo) begin
      loHold  <= busData;
      loValid <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdPtr <= '0;
      wrPtr <= '0;
      count <= '0;
    end else begin
      if (commit) wrPtr <= bump(wrPtr);
      if (pop)    rdPtr <= bump(rdPtr);
      case ({commit, pop})
        2'b10:   count <= count + CNT_W'(1);
        2'b01:   count <= count - CNT_W'(1);
        default: count <= count;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             shiftReg <= '0;
    else if (pop)          shiftReg <= {parityBit, headWord};
    else if (strb.nextBit) shiftReg <= {1'b0, shiftReg[WORD_BITS-1:1]};
  end

  assign levelA = strb.drive & shiftReg[0];
  assign levelB = strb.drive & ~shiftReg[0];

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    (count == CNT_W'(DEPTH) && !pop) |=> (count == CNT_W'(DEPTH))); // R3

  AST_POP_HAS_WORD: assert property (@(posedge clk) disable iff (!rstN)
    pop |-> (count != '0)); // R9

  AST_PARITY_SENSE: assert property (@(posedge clk) disable iff (!rstN)
    $past(pop) |-> ((^shiftReg) != $past(evenParity))); // R7

endmodule

// File: rtl/a429_tx_ctrl.sv
module a429_tx_ctrl
  import a429_tx_pkg::*;
#(
  parameter int DIV_FAST  = 10,
  parameter int DIV_SLOW  = 80,
  parameter int GAP_BITS  = 4,
  parameter int WORD_BITS = 32
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      startEn,
  input  logic      slowRate,
  input  logic      fifoEmpty,
  output txStrobe_t strb,
  output logic      txReady
);

  localparam int HALF_FAST  = DIV_FAST / 2;
  localparam int HALF_SLOW  = DIV_SLOW / 2;
  localparam int GAP_HALVES = 2 * GAP_BITS;
  localparam int CNT_W      = $clog2(HALF_SLOW * GAP_HALVES);
  localparam int BIT_W      = $clog2(WORD_BITS);

  txState_e         state;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] lastCnt;
  logic [BIT_W-1:0] bitIdx;
  logic             atEnd;
  logic             canStart;
  logic             lastBit;

  always_comb begin
    if (state == ST_GAP)
      lastCnt = slowRate ? CNT_W'(HALF_SLOW * GAP_HALVES - 1) : CNT_W'(HALF_FAST * GAP_HALVES - 1);
    else
      lastCnt = slowRate ? CNT_W'(HALF_SLOW - 1) : CNT_W'(HALF_FAST - 1);
  end

  assign atEnd    = (cnt == lastCnt);
  assign canStart = startEn && !fifoEmpty;
  assign lastBit  = (bitIdx == BIT_W'(WORD_BITS - 1));

  assign strb.loadWord = ((state == ST_IDLE) || (state == ST_GAP && atEnd)) && canStart;
  assign strb.nextBit  = (state == ST_SPACE) && atEnd;
  assign strb.drive    = (state == ST_MARK);
  assign txReady       = fifoEmpty && ((state == ST_IDLE) || (state == ST_GAP));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      cnt    <= '0;
      bitIdx <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (strb.loadWord) begin
            state  <= ST_MARK;
            cnt    <= '0;
            bitIdx <= '0;
          end
        end
        ST_MARK: begin
          if (atEnd) begin
            cnt   <= '0;
            state <= lastBit ? ST_GAP : ST_SPACE;
          end else cnt <= cnt + CNT_W'(1);
        end
        ST_SPACE: begin
          if (atEnd) begin
            cnt    <= '0;
            bitIdx <= bitIdx + BIT_W'(1);
            state  <= ST_MARK;
          end else cnt <= cnt + CNT_W'(1);
        end
        default: begin
          if (atEnd) begin
            cnt    <= '0;
            bitIdx <= '0;
            state  <= strb.loadWord ? ST_MARK : ST_IDLE;
          end else cnt <= cnt + CNT_W'(1);
        end
      endcase
    end
  end

  AST_SPACE_AFTER_MARK: assert property (@(posedge clk) disable iff (!rstN)
    $rose(state == ST_SPACE) |-> ($past(state) == ST_MARK)); // R5

  AST_GAP_AFTER_LAST: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_GAP) |-> lastBit); // R8

endmodule

// File: rtl/a429_tx.sv
module a429_tx
  import a429_tx_pkg::*;
#(
  parameter int DEPTH     = 8,
  parameter int WORD_BITS = 32,
  parameter int BUS_W     = 16,
  parameter int DIV_FAST  = 10,
  parameter int DIV_SLOW  = 80,
  parameter int GAP_BITS  = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [BUS_W-1:0] busData,
  input  logic             loadLo,
  input  logic             loadHi,
  input  logic             startEn,
  input  logic             slowRate,
  input  logic             evenParity,
  input  logic             lineTest,
  input  logic             loopEn,
  output logic             txReady,
  output logic             lineA,
  output logic             lineB,
  output logic             loopRx1A,
  output logic             loopRx1B,
  output logic             loopRx2A,
  output logic             loopRx2B
);

  txStrobe_t strb;
  logic      fifoEmpty;
  logic      levelA;
  logic      levelB;

  a429_tx_ctrl #(
    .DIV_FAST (DIV_FAST),
    .DIV_SLOW (DIV_SLOW),
    .GAP_BITS (GAP_BITS),
    .WORD_BITS(WORD_BITS)
  ) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .startEn  (startEn),
    .slowRate (slowRate),
    .fifoEmpty(fifoEmpty),
    .strb     (strb),
    .txReady  (txReady)
  );

  a429_tx_path #(
    .DEPTH    (DEPTH),
    .WORD_BITS(WORD_BITS),
    .BUS_W    (BUS_W)
  ) uPath (
    .clk       (clk),
    .rstN      (rstN),
    .busData   (busData),
    .loadLo    (loadLo),
    .loadHi    (loadHi),
    .evenParity(evenParity),
    .strb      (strb),
    .fifoEmpty (fifoEmpty),
    .levelA    (levelA),
    .levelB    (levelB)
  );

  assign lineA    = levelA & ~lineTest;
  assign lineB    = levelB & ~lineTest;
  assign loopRx1A = loopEn & levelA;
  assign loopRx1B = loopEn & levelB;
  assign loopRx2A = loopEn & levelB;
  assign loopRx2B = loopEn & levelA;

endmodule

// File: tb/a429_tx_test.sv
`timescale 1ns/1ps
module a429_tx_test;

  localparam int LIMIT = 150000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] busData = '0;
  logic        loadLo = 1'b0, loadHi = 1'b0, startEn = 1'b0, slowRate = 1'b0;
  logic        evenParity = 1'b0, lineTest = 1'b0, loopEn = 1'b0;
  logic        txReady, lineA, lineB, loopRx1A, loopRx1B, loopRx2A, loopRx2B;

  int    vectors = 0;
  int    miscompares = 0;
  int    cycles = 0;
  int    pulses = 0;
  bit    runCmp = 1'b0;
  bit    prevOn = 1'b0;
  string curTag = "R5";

  // reference model state
  int          waveQ[$];     // per-cycle level: 0 zero, 1 one, 2 null
  logic [30:0] fifoQ[$];
  logic [15:0] mLo;
  bit          mLoValid = 1'b0;
  int          curLvl = 2;
  int          gapModel = 40;
  logic [30:0] mW;
  logic        mP;
  int          mHalf;

  always #4 clk = ~clk;

  a429_tx uut (
    .clk(clk), .rstN(rstN), .busData(busData), .loadLo(loadLo), .loadHi(loadHi),
    .startEn(startEn), .slowRate(slowRate), .evenParity(evenParity),
    .lineTest(lineTest), .loopEn(loopEn), .txReady(txReady), .lineA(lineA),
    .lineB(lineB), .loopRx1A(loopRx1A), .loopRx1B(loopRx1B),
    .loopRx2A(loopRx2A), .loopRx2B(loopRx2B)
  );

  task automatic check(input string tag, input string what, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s %s actual=%0d expected=%0d at cycle %0d", tag, what, act, exp, cycles);
    end
  endtask

  // reference model: advances on each clock edge
  always @(posedge clk) begin
    if (!rstN) begin
      waveQ.delete();
      fifoQ.delete();
      mLoValid = 1'b0;
      curLvl   = 2;
    end else begin
      if (waveQ.size() > 0) begin
        curLvl = waveQ.pop_front();
      end else if (startEn && fifoQ.size() > 0) begin
        mW = fifoQ.pop_front();
        mP = evenParity ? (^mW) : ~(^mW);        // R7
        mHalf = slowRate ? 40 : 5;
        gapModel = 8 * mHalf;
        for (int i = 0; i < 32; i++) begin
          int lv;
          lv = (i < 31) ? int'(mW[i]) : int'(mP);
          for (int k = 0; k < mHalf; k++) waveQ.push_back(lv);
          for (int k = 0; k < ((i < 31) ? mHalf : 8 * mHalf); k++) waveQ.push_back(2);
        end
        curLvl = waveQ.pop_front();
      end else begin
        curLvl = 2;
      end
      if (loadHi) begin
        if (mLoValid && fifoQ.size() < 8) fifoQ.push_back({busData[14:0], mLo});
        mLoValid = 1'b0;
      end else if (loadLo) begin
        mLo = busData;
        mLoValid = 1'b1;
      end
    end
  end

  // compare away from the active edge
  always @(posedge clk) begin
    cycles++;
    #2;
    if (rstN && runCmp) begin
      int eA, eB;
      eA = (curLvl == 1);
      eB = (curLvl == 0);
      check(curTag, "lineA", int'(lineA), lineTest ? 0 : eA);  // R10
      check(curTag, "lineB", int'(lineB), lineTest ? 0 : eB);
      check("R4", "txReady", int'(txReady),
            int'(fifoQ.size() == 0 && waveQ.size() < gapModel));
      check("R12", "loop", int'({loopRx1A, loopRx1B, loopRx2A, loopRx2B}),
            loopEn ? int'({eA[0], eB[0], eB[0], eA[0]}) : 0);
      if ((lineA || lineB) && !prevOn) pulses++;
      prevOn = lineA || lineB;
    end
    if (cycles > LIMIT) begin
      miscompares++;
      $display("FAIL watchdog expired actual=%0d expected<=%0d", cycles, LIMIT);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  task automatic loadWord(input logic [30:0] w, input logic spare);
    @(negedge clk);
    busData = w[15:0];
    loadLo  = 1'b1;
    @(negedge clk);
    loadLo  = 1'b0;
    busData = {spare, w[30:16]};
    loadHi  = 1'b1;
    @(negedge clk);
    loadHi  = 1'b0;
    busData = '0;
  endtask

  task automatic waitDrain();
    while (waveQ.size() != 0 || fifoQ.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1", "reset txReady", int'(txReady), 1);
    check("R1", "reset lines", int'({lineA, lineB}), 0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1", "post-reset txReady", int'(txReady), 1);
    runCmp = 1'b1;

    // R2: high half alone commits nothing
    curTag = "R2";
    @(negedge clk);
    busData = 16'hFFFF;
    loadHi  = 1'b1;
    @(negedge clk);
    loadHi  = 1'b0;
    repeat (2) @(negedge clk);
    check("R2", "txReady after lone high half", int'(txReady), 1);
    // R2: second low half overrides first; bit 15 of high half ignored
    @(negedge clk);
    busData = 16'h1234; loadLo = 1'b1;
    @(negedge clk);
    busData = 16'hA5C3;
    @(negedge clk);
    loadLo = 1'b0; busData = 16'h8F0F; loadHi = 1'b1;
    @(negedge clk);
    loadHi = 1'b0;
    check("R4", "txReady after commit", int'(txReady), 0);
    startEn = 1'b1;
    waitDrain();
    startEn = 1'b0;

    // R10 / R6: plain fast word
    curTag = "R6";
    loadWord(31'h2AAA_5555, 1'b1);
    startEn = 1'b1;
    waitDrain();
    curTag = "R10";
    loadWord(31'h0000_0001, 1'b0);
    waitDrain();

    // R5: slow rate
    startEn = 1'b0;
    slowRate = 1'b1;
    curTag = "R5";
    loadWord(31'h1357_9BDF, 1'b0);
    startEn = 1'b1;
    waitDrain();
    slowRate = 1'b0;

    // R7 / R8: even parity, two words back to back
    evenParity = 1'b1;
    startEn = 1'b0;
    curTag = "R7";
    loadWord(31'h0000_0003, 1'b0);
    loadWord(31'h7FFF_FFFF, 1'b0);
    curTag = "R8";
    startEn = 1'b1;
    waitDrain();
    evenParity = 1'b0;

    // R3: nine loads into an eight-entry queue
    startEn = 1'b0;
    curTag = "R3";
    for (int n = 0; n < 9; n++) loadWord(31'(32'h0101_0101 * (n + 1)), 1'b0);
    check("R3", "txReady with full queue", int'(txReady), 0);
    pulses = 0;
    startEn = 1'b1;
    waitDrain();
    check("R3", "data pulses for full queue", pulses, 8 * 32);

    // R9: drop enable mid-word
    startEn = 1'b0;
    curTag = "R9";
    loadWord(31'h0F0F_0F0F, 1'b0);
    loadWord(31'h7070_7070, 1'b0);
    startEn = 1'b1;
    repeat (60) @(negedge clk);
    startEn = 1'b0;
    repeat (600) @(negedge clk);
    check("R9", "txReady with word held", int'(txReady), 0);
    check("R9", "lines idle", int'({lineA, lineB}), 0);
    startEn = 1'b1;
    waitDrain();

    // R12 / R11: loopback, then test forcing
    startEn = 1'b0;
    loopEn = 1'b1;
    curTag = "R12";
    loadWord(31'h3C3C_C3C3, 1'b0);
    startEn = 1'b1;
    repeat (100) @(negedge clk);
    lineTest = 1'b1;
    curTag = "R11";
    repeat (120) @(negedge clk);
    check("R11", "lines under test", int'({lineA, lineB}), 0);
    lineTest = 1'b0;
    waitDrain();
    loopEn = 1'b0;

    repeat (5) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule